// File: doc/BRIEF.md
# Buddy Frame Allocator

This block hands out and takes back contiguous runs of physical frames from a pool of 2^POOL_ORDER frames (64 by default). It uses the binary buddy scheme. Every block is a power of two in size and sits on a boundary that matches its own size. An allocation finds the smallest free block that can hold the request. If that block is larger than needed, it is halved step by step: at each step the lower half is kept and the upper half goes back on the free lists. A release puts a block back and merges it with its buddy, the neighbour at `addr XOR size`, for as long as that buddy is free at the current order.

The free state is held as one bitmap per order, from order 0 (single frames) up to order POOL_ORDER (the whole pool). Requests use a simple valid/ready handshake. Only one request is in flight at a time. Each split or merge step takes one cycle, and one response pulse reports the result.

Top module: `buddy_frame_alloc`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0, and the whole pool is one free block at frame 0, so an allocation of the full pool size returns start 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low until the single-cycle `rsp_valid_o` pulse for that request, and it is high again in the cycle after the pulse.
- R3: `req_count_i` must be a power of two from 1 to 2^POOL_ORDER, where order k means count 2^k. Any other value, including 0, gives `rsp_fail_o`=1 and leaves the free state unchanged.
- R4: An allocation with `req_free_i`=0 uses the smallest free order that is at least the requested order, and within that order the block with the lowest address. The returned start is a multiple of the requested count.
- R5: When a block of order j serves a request of order k<j, the upper halves produced at orders j-1 down to k each become free blocks.
- R6: If no free block of sufficient order exists, the allocation responds with `rsp_fail_o`=1 and the free state is unchanged.
- R7: A release with `req_free_i`=1 merges the block with its buddy (start XOR count) while that buddy is free, and repeats at each higher order. It responds with `rsp_fail_o`=0 and `rsp_start_o` equal to the start of the final merged block.
- R8: A release whose start is not a multiple of its count responds with `rsp_fail_o`=1 and changes nothing.
- R9: From reset, the sequence alloc 4, alloc 4, free 4 at 4, alloc 8, alloc 2 returns starts 0, 4, 4, 8, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be accepted |
| req_free_i | input | 1 | 0 allocate, 1 release |
| req_count_i | input | POOL_ORDER+1 | Frame count (power of two) |
| req_start_i | input | POOL_ORDER | Start frame for a release |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_fail_o | output | 1 | Request refused |
| rsp_start_o | output | POOL_ORDER | Allocated start, or merged block start on release |

## Verification
A bitmap bit that is lost or set by mistake does not show up at once. It appears only at the next allocation that would pick that block. There it causes a wrong start, two allocations that overlap, or a false refusal. A missed merge appears only when a larger allocation later fails or lands at an unexpected address. For this reason, every response is compared with a reference model. The run ends by releasing all blocks and allocating the full pool, which shows at the ports any fragment that failed to merge back.

// File: rtl/buddy_alloc_pkg.sv
package buddy_alloc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_MERGE,
    ST_RESP
  } buddy_state_e;

  // Orders are packed low to high in one flat vector; order k starts here.
  function automatic int order_base(input int pool_order, input int ord);
    return (32'sd1 <<< (pool_order + 1)) - (32'sd1 <<< (pool_order - ord + 1));
  endfunction

endpackage

// File: rtl/buddy_count_decode.sv
module buddy_count_decode #(
  parameter int POOL_ORDER = 6,
  localparam int CNT_W = POOL_ORDER + 1,
  localparam int ORD_W = $clog2(POOL_ORDER + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             ok_o,
  output logic [ORD_W-1:0] order_o
);

  always_comb begin
    ok_o    = (count_i != '0) && ((count_i & (count_i - CNT_W'(1))) == '0);
    order_o = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (count_i[b]) order_o = ORD_W'(b);
    end
  end

endmodule

// File: rtl/buddy_free_map.sv
module buddy_free_map #(
  parameter int POOL_ORDER = 6,
  localparam int NODES  = (2 ** (POOL_ORDER + 1)) - 1,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NODE_W-1:0] wr_node_i,
  input  logic              wr_val_i,
  output logic [NODES-1:0]  map_o
);

  logic [NODES-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q            <= '0;
      map_q[NODES-1]   <= 1'b1;  // whole pool free
    end else if (wr_en_i) begin
      map_q[wr_node_i] <= wr_val_i;
    end
  end

  assign map_o = map_q;

  // A block is never marked free twice, nor taken when not free.
  assert_set_was_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_val_i) |-> !map_q[wr_node_i]);
  assert_clear_was_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_val_i) |-> map_q[wr_node_i]);

endmodule

// File: rtl/buddy_pick.sv
module buddy_pick #(
  parameter int POOL_ORDER = 6,
  localparam int NODES  = (2 ** (POOL_ORDER + 1)) - 1,
  localparam int ORD_W  = $clog2(POOL_ORDER + 1),
  localparam int ADDR_W = POOL_ORDER
) (
  input  logic [NODES-1:0]  map_i,
  input  logic [ORD_W-1:0]  min_order_i,
  output logic              found_o,
  output logic [ORD_W-1:0]  order_o,
  output logic [ADDR_W-1:0] index_o
);

  logic [POOL_ORDER:0] any_w;
  logic [ADDR_W-1:0]   idx_w [POOL_ORDER+1];

  for (genvar k = 0; k <= POOL_ORDER; k++) begin : g_ord
    localparam int CNT  = 2 ** (POOL_ORDER - k);
    localparam int BASE = buddy_alloc_pkg::order_base(POOL_ORDER, k);
    logic              any_k;
    logic [ADDR_W-1:0] idx_k;
    always_comb begin
      any_k = 1'b0;
      idx_k = '0;
      for (int i = CNT - 1; i >= 0; i--) begin
        if (map_i[BASE+i]) begin
          any_k = 1'b1;
          idx_k = ADDR_W'(i);
        end
      end
    end
    assign any_w[k] = any_k;
    assign idx_w[k] = idx_k;
  end

  // Smallest sufficient order wins.
  always_comb begin
    found_o = 1'b0;
    order_o = '0;
    index_o = '0;
    for (int j = POOL_ORDER; j >= 0; j--) begin
      if (j >= int'(min_order_i) && any_w[j]) begin
        found_o = 1'b1;
        order_o = ORD_W'(j);
        index_o = idx_w[j];
      end
    end
  end

endmodule

// File: rtl/buddy_frame_alloc.sv
module buddy_frame_alloc #(
  parameter int POOL_ORDER = 6,
  localparam int CNT_W  = POOL_ORDER + 1,
  localparam int ADDR_W = POOL_ORDER,
  localparam int ORD_W  = $clog2(POOL_ORDER + 1),
  localparam int NODES  = (2 ** (POOL_ORDER + 1)) - 1,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_free_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [ADDR_W-1:0] req_start_i,
  output logic              rsp_valid_o,
  output logic              rsp_fail_o,
  output logic [ADDR_W-1:0] rsp_start_o
);
  import buddy_alloc_pkg::*;

  buddy_state_e      state_q;
  logic [ORD_W-1:0]  cur_ord_q, tgt_ord_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic              fail_q, op_free_q;

  logic              dec_ok;
  logic [ORD_W-1:0]  dec_order;
  logic              pick_found;
  logic [ORD_W-1:0]  pick_order;
  logic [ADDR_W-1:0] pick_index;
  logic [NODES-1:0]  free_map;
  logic              wr_en, wr_val;
  logic [NODE_W-1:0] wr_node;

  function automatic logic [NODE_W-1:0] node_at(input logic [ORD_W-1:0] ord,
                                                input logic [ADDR_W-1:0] idx);
    return NODE_W'(order_base(POOL_ORDER, int'(ord)) + int'(idx));
  endfunction

  function automatic logic [ADDR_W-1:0] low_mask(input logic [ORD_W-1:0] ord);
    return ADDR_W'((32'd1 << ord) - 32'd1);
  endfunction

  buddy_count_decode #(.POOL_ORDER(POOL_ORDER)) u_dec (
    .count_i (req_count_i),
    .ok_o    (dec_ok),
    .order_o (dec_order)
  );

  buddy_pick #(.POOL_ORDER(POOL_ORDER)) u_pick (
    .map_i       (free_map),
    .min_order_i (dec_order),
    .found_o     (pick_found),
    .order_o     (pick_order),
    .index_o     (pick_index)
  );

  buddy_free_map #(.POOL_ORDER(POOL_ORDER)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_node_i (wr_node),
    .wr_val_i  (wr_val),
    .map_o     (free_map)
  );

  // Split step: next lower order and the upper half at that order.
  logic [ORD_W-1:0]  split_ord;
  logic [ADDR_W-1:0] split_idx;
  assign split_ord = cur_ord_q - ORD_W'(1);
  assign split_idx = (cur_addr_q >> split_ord) | ADDR_W'(1);

  // Merge step: buddy of the current block at the current order.
  logic              at_top;
  logic [ADDR_W-1:0] self_idx;
  logic [NODE_W-1:0] buddy_node, self_node;
  logic              merge_go;
  assign at_top     = (cur_ord_q == ORD_W'(POOL_ORDER));
  assign self_idx   = cur_addr_q >> cur_ord_q;
  assign self_node  = node_at(cur_ord_q, self_idx);
  assign buddy_node = at_top ? self_node : node_at(cur_ord_q, self_idx ^ ADDR_W'(1));
  assign merge_go   = !at_top && free_map[buddy_node];

  logic accept, misaligned;
  assign accept     = req_valid_i && req_ready_o;
  assign misaligned = (req_start_i & low_mask(dec_order)) != '0;

  always_comb begin
    wr_en   = 1'b0;
    wr_val  = 1'b0;
    wr_node = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !req_free_i && dec_ok && pick_found) begin
          wr_en   = 1'b1;
          wr_node = node_at(pick_order, pick_index);
        end
      end
      ST_SPLIT: begin
        wr_en   = 1'b1;
        wr_val  = 1'b1;
        wr_node = node_at(split_ord, split_idx);
      end
      ST_MERGE: begin
        wr_en   = 1'b1;
        wr_val  = !merge_go;
        wr_node = merge_go ? buddy_node : self_node;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_ord_q  <= '0;
      tgt_ord_q  <= '0;
      cur_addr_q <= '0;
      fail_q     <= 1'b0;
      op_free_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_free_q <= req_free_i;
            tgt_ord_q <= dec_order;
            fail_q    <= 1'b0;
            if (!dec_ok) begin
              fail_q     <= 1'b1;
              cur_addr_q <= '0;
              state_q    <= ST_RESP;
            end else if (!req_free_i) begin
              if (!pick_found) begin
                fail_q     <= 1'b1;
                cur_addr_q <= '0;
                state_q    <= ST_RESP;
              end else begin
                cur_ord_q  <= pick_order;
                cur_addr_q <= ADDR_W'(pick_index << pick_order);
                state_q    <= (pick_order == dec_order) ? ST_RESP : ST_SPLIT;
              end
            end else if (misaligned) begin
              fail_q     <= 1'b1;
              cur_addr_q <= '0;
              state_q    <= ST_RESP;
            end else begin
              cur_ord_q  <= dec_order;
              cur_addr_q <= req_start_i;
              state_q    <= ST_MERGE;
            end
          end
        end
        ST_SPLIT: begin
          cur_ord_q <= split_ord;
          if (split_ord == tgt_ord_q) state_q <= ST_RESP;
        end
        ST_MERGE: begin
          if (merge_go) begin
            cur_addr_q <= cur_addr_q & ~ADDR_W'(32'd1 << cur_ord_q);
            cur_ord_q  <= cur_ord_q + ORD_W'(1);
          end else begin
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_fail_o  = fail_q;
  assign rsp_start_o = cur_addr_q;

  assert_rsp_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_alloc_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fail_o && !op_free_q) |-> ((rsp_start_o & low_mask(tgt_ord_q)) == '0));
  assert_pick_is_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_free_i && dec_ok && pick_found) |-> free_map[node_at(pick_order, pick_index)]);
  assert_split_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SPLIT) |-> (cur_ord_q > tgt_ord_q));
  assert_fail_keeps_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fail_o) |-> $stable(free_map));

endmodule

// File: tb/buddy_frame_alloc_tb_top.sv
`timescale 1ns/1ps
module buddy_frame_alloc_tb_top;
  localparam int N = 6;
  localparam int FR = 2 ** N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_free = 1'b0;
  logic [N:0]   req_count = '0;
  logic [N-1:0] req_start = '0;
  logic req_ready, rsp_valid, rsp_fail;
  logic [N-1:0] rsp_start;

  always #2 clk = ~clk;

  buddy_frame_alloc #(.POOL_ORDER(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_free_i(req_free), .req_count_i(req_count), .req_start_i(req_start),
    .rsp_valid_o(rsp_valid), .rsp_fail_o(rsp_fail), .rsp_start_o(rsp_start)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: free flag per order and block index.
  bit mfree [N+1][FR];

  task automatic model_reset();
    for (int k = 0; k <= N; k++)
      for (int i = 0; i < FR; i++) mfree[k][i] = 1'b0;
    mfree[N][0] = 1'b1;
  endtask

  task automatic model_alloc(input int k, output bit fail, output int start);
    int j, idx;
    j = -1; idx = 0;
    for (int o = k; o <= N && j < 0; o++)
      for (int i = 0; i < (FR >> o); i++)
        if (j < 0 && mfree[o][i]) begin j = o; idx = i; end
    if (j < 0) begin fail = 1'b1; start = 0; return; end
    fail = 1'b0;
    mfree[j][idx] = 1'b0;
    start = idx << j;
    for (int s = j - 1; s >= k; s--) mfree[s][(start >> s) + 1] = 1'b1;
  endtask

  task automatic model_free(input int a, input int k, output int start);
    while (k < N && mfree[k][(a >> k) ^ 1]) begin
      mfree[k][(a >> k) ^ 1] = 1'b0;
      a = a & ~(1 << k);
      k++;
    end
    mfree[k][a >> k] = 1'b1;
    start = a;
  endtask

  task automatic do_req(input bit fr, input int cnt, input int st,
                        output bit fail, output int start);
    int wait_c;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_free = fr;
    req_count = (N+1)'(cnt); req_start = N'(st);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready || rsp_valid, "R2 busy after accept", int'(req_ready), 0);
    wait_c = 0;
    while (!rsp_valid && wait_c < 100) begin @(negedge clk); wait_c++; end
    chk(rsp_valid, "R2 response arrives", int'(rsp_valid), 1);
    fail = rsp_fail; start = int'(rsp_start);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R2 single pulse then ready", int'(rsp_valid), 0);
  endtask

  task automatic alloc_chk(input int cnt, input bit exp_fail, input int exp_start, input string req);
    bit f; int s;
    do_req(1'b0, cnt, 0, f, s);
    chk(f == exp_fail, {req, " fail flag"}, int'(f), int'(exp_fail));
    if (!exp_fail) chk(s == exp_start, {req, " start"}, s, exp_start);
  endtask

  task automatic free_chk(input int st, input int cnt, input bit exp_fail, input int exp_start, input string req);
    bit f; int s;
    do_req(1'b1, cnt, st, f, s);
    chk(f == exp_fail, {req, " fail flag"}, int'(f), int'(exp_fail));
    if (!exp_fail) chk(s == exp_start, {req, " merged start"}, s, exp_start);
  endtask

  int al_start [FR];
  int al_ord [FR];
  int n_al = 0;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit f; int s, e, k, pick;
    void'($urandom(32'h1b5d_0c07));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    model_reset();

    // R1: full pool free at frame 0
    alloc_chk(64, 1'b0, 0, "R1 full pool");
    alloc_chk(1, 1'b1, 0, "R6 empty pool");
    free_chk(0, 64, 1'b0, 0, "R7 release pool");

    // R9 directed sequence
    alloc_chk(4, 1'b0, 0, "R9 step1");
    alloc_chk(4, 1'b0, 4, "R9 step2");
    free_chk(4, 4, 1'b0, 4, "R9 step3");
    alloc_chk(8, 1'b0, 8, "R9 step4");
    alloc_chk(2, 1'b0, 4, "R9 step5");
    // R5: upper half left by the last split
    alloc_chk(2, 1'b0, 6, "R5 upper half reuse");
    alloc_chk(16, 1'b0, 16, "R5 order4 half");
    alloc_chk(32, 1'b0, 32, "R5 order5 half");
    alloc_chk(1, 1'b1, 0, "R6 exhausted");
    // R3 invalid counts
    alloc_chk(3, 1'b1, 0, "R3 count 3");
    alloc_chk(0, 1'b1, 0, "R3 count 0");
    alloc_chk(96, 1'b1, 0, "R3 count 96");
    // R8 misaligned release
    free_chk(2, 4, 1'b1, 0, "R8 misaligned");
    // R7 release all, merging to whole pool
    free_chk(6, 2, 1'b0, 6, "R7 no merge 6");
    free_chk(4, 2, 1'b0, 4, "R7 merge to 4");
    free_chk(0, 4, 1'b0, 0, "R7 merge to 0");
    free_chk(8, 8, 1'b0, 0, "R7 merge to 16");
    free_chk(16, 16, 1'b0, 0, "R7 merge to 32");
    free_chk(32, 32, 1'b0, 0, "R7 merge to pool");
    alloc_chk(64, 1'b0, 0, "R7 full pool after merges");
    free_chk(0, 64, 1'b0, 0, "R7 pool back");

    // Random mix checked against the model (R4, R7)
    model_reset();
    for (int it = 0; it < 400; it++) begin
      if (n_al == 0 || ($urandom % 100) < 55) begin
        k = ($urandom % 8 == 0) ? int'($urandom % (N + 1)) : int'($urandom % 4);
        model_alloc(k, f, e);
        alloc_chk(1 << k, f, e, "R4 random alloc");
        if (!f) begin al_start[n_al] = e; al_ord[n_al] = k; n_al++; end
      end else begin
        pick = int'($urandom % n_al);
        model_free(al_start[pick], al_ord[pick], e);
        free_chk(al_start[pick], 1 << al_ord[pick], 1'b0, e, "R7 random free");
        n_al--;
        al_start[pick] = al_start[n_al];
        al_ord[pick] = al_ord[n_al];
      end
    end
    while (n_al > 0) begin
      n_al--;
      model_free(al_start[n_al], al_ord[n_al], e);
      free_chk(al_start[n_al], 1 << al_ord[n_al], 1'b0, e, "R7 drain");
    end
    alloc_chk(64, 1'b0, 0, "R7 pool whole after drain");
    s = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail + s);
    $finish;
  end

endmodule